// File: doc/BRIEF.md
# Flow-Control Pause Frame Receive Detector

This block sits beside a receive path that delivers frame bytes one at a time. It checks each frame against the fields that mark a pause control frame and asks the transmitter to hold off when one arrives. It compares the destination address against the configured station address and against the reserved flow-control multicast address. It also checks the length/type field, the opcode, and the 16-bit pause quantum that follows the opcode.

Every comparison result is collected while the frame streams in. No output moves until the receive path gives its end-of-frame verdict. A good verdict turns the collected results into either a one-cycle pause request, which carries the captured quantum, or a one-cycle bad-opcode status pulse. A bad verdict throws everything away. A separate enable input lets the receive side stop acting on pause frames without affecting anything on the transmit side.

Top module: `flowctl_pause_rx`

## Requirements
- R1: After reset, `pause_req` and `bad_opcode` are 0 and `pause_quanta` is 0x0000.
- R2: Byte 0 is the first byte with `rx_vld` high after a verdict or after reset. A frame is qualifying when all of the following hold: its destination (bytes 0-5) matches `station_mac`; bytes 12-13 are 0x88, 0x08; bytes 14-15 are 0x00, 0x01; and at least 18 bytes arrived. If such a frame ends with `rx_good` high while `pause_en` is 1, then `pause_req` is 1 in the cycle after the verdict cycle. In that same cycle `pause_quanta` equals byte 16 in bits 15:8 and byte 17 in bits 7:0.
- R3: A destination of 01-80-C2-00-00-01 qualifies in the same way as the station address.
- R4: `station_mac` holds the first received address byte in bits 7:0 and the sixth in bits 47:40, so AA-BB-CC-DD-EE-FF is 48'hFFEEDDCCBBAA.
- R5: A frame whose destination matches neither address produces no request.
- R6: A frame whose type is not 0x8808 produces neither a request nor a bad-opcode pulse.
- R7: A frame that has type 0x8808, has an opcode other than 0x0001, and ends with `rx_good` pulses `bad_opcode` for one cycle after the verdict. This happens regardless of the destination address or `pause_en`, and it produces no request.
- R8: A frame ending with `rx_bad` produces no output pulse and leaves `pause_quanta` unchanged. If `rx_good` and `rx_bad` are high together, the frame is treated as bad.
- R9: With `pause_en` at 0, a qualifying frame produces no request and leaves `pause_quanta` unchanged.
- R10: A frame that ends before byte 17 produces no request.
- R11: `pause_req` and `bad_opcode` are single-cycle pulses. `pause_quanta` changes only together with a request and holds its value otherwise.
- R12: Bytes after byte 17 have no effect on the verdict or the quantum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte | input | 8 | Received frame byte |
| rx_vld | input | 1 | `rx_byte` carries a frame byte |
| rx_good | input | 1 | End-of-frame strobe, frame error-free |
| rx_bad | input | 1 | End-of-frame strobe, frame in error |
| station_mac | input | 48 | Configured station address, first byte lowest |
| pause_en | input | 1 | Act on received pause frames |
| pause_req | output | 1 | One-cycle request to hold off transmission |
| pause_quanta | output | 16 | Quantum of the latest request |
| bad_opcode | output | 1 | One-cycle pulse for a control frame with a non-pause opcode |

## Verification
The bench builds the block with the default 5-bit byte index. That is enough to reach the saturating end of the index with 64-byte frames, so the test shows that the quantum stays latched however long the frame runs on. Both the 17-byte short frame and the 18-byte minimum qualifying frame fall inside that index range, which exercises the length boundary from both sides. Each verdict is followed by one more sampled cycle to confirm that each output pulse lasts exactly one cycle.

// File: rtl/flowctl_pause_rx.sv
module flowctl_pause_rx #(
  parameter int CNT_W = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  rx_byte,
  input  logic        rx_vld,
  input  logic        rx_good,
  input  logic        rx_bad,
  input  logic [47:0] station_mac,
  input  logic        pause_en,
  output logic        pause_req,
  output logic [15:0] pause_quanta,
  output logic        bad_opcode
);
  localparam logic [CNT_W-1:0] IDX_MAX = {CNT_W{1'b1}};
  localparam logic [47:0]      MC_ADDR = 48'h01_00_00_C2_80_01;

  logic [CNT_W-1:0] idx;
  logic             da_st, da_mc, ty_ok, op_ok;
  logic [15:0]      qcap;

  wire verdict  = rx_good | rx_bad;
  wire good     = rx_good & ~rx_bad;
  wire in_da    = idx < CNT_W'(6);
  wire [7:0] st_b = station_mac[{idx[2:0], 3'b000} +: 8];
  wire [7:0] mc_b = MC_ADDR[{idx[2:0], 3'b000} +: 8];
  wire qual     = (da_st | da_mc) & ty_ok & op_ok & (idx > CNT_W'(17));
  wire fire     = good & pause_en & qual;

  always_ff @(posedge clk) begin
    if (!rst_n || verdict) begin
      idx   <= '0;
      da_st <= 1'b1;
      da_mc <= 1'b1;
      ty_ok <= 1'b1;
      op_ok <= 1'b1;
    end else if (rx_vld) begin
      if (idx != IDX_MAX) idx <= idx + 1'b1;
      if (in_da && rx_byte != st_b) da_st <= 1'b0;
      if (in_da && rx_byte != mc_b) da_mc <= 1'b0;
      if (idx == CNT_W'(12) && rx_byte != 8'h88) ty_ok <= 1'b0;
      if (idx == CNT_W'(13) && rx_byte != 8'h08) ty_ok <= 1'b0;
      if (idx == CNT_W'(14) && rx_byte != 8'h00) op_ok <= 1'b0;
      if (idx == CNT_W'(15) && rx_byte != 8'h01) op_ok <= 1'b0;
      if (idx == CNT_W'(16)) qcap[15:8] <= rx_byte;
      if (idx == CNT_W'(17)) qcap[7:0]  <= rx_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pause_req    <= 1'b0;
      bad_opcode   <= 1'b0;
      pause_quanta <= '0;
    end else begin
      pause_req  <= fire;
      bad_opcode <= good & ty_ok & ~op_ok & (idx > CNT_W'(15));
      if (fire) pause_quanta <= qcap;
    end
  end

  p_req_after_good_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pause_req |-> $past(rx_good) && !$past(rx_bad));
  p_bad_silences_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_bad |=> !pause_req && !bad_opcode);
  p_en_gates_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pause_req |-> $past(pause_en));
  p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pause_req && bad_opcode));
  p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pause_req |=> !pause_req);
  p_quanta_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !pause_req |-> $stable(pause_quanta));
endmodule

// File: tb/test_flowctl_pause_rx.sv
module test_flowctl_pause_rx;
  logic clk = 0, rst_n = 0;
  logic [7:0] rx_byte = 0;
  logic rx_vld = 0, rx_good = 0, rx_bad = 0, pause_en = 1;
  logic [47:0] station_mac = 48'hFFEEDDCCBBAA;
  logic pause_req, bad_opcode;
  logic [15:0] pause_quanta;
  int checks = 0, errors = 0;
  logic [7:0] fr [0:63];
  bit done = 0;

  always #4 clk = ~clk;

  flowctl_pause_rx i_flowctl_pause_rx (
    .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_vld(rx_vld),
    .rx_good(rx_good), .rx_bad(rx_bad), .station_mac(station_mac),
    .pause_en(pause_en), .pause_req(pause_req), .pause_quanta(pause_quanta),
    .bad_opcode(bad_opcode));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic build(logic [47:0] da, logic [15:0] ty, logic [15:0] op, logic [15:0] q);
    for (int i = 0; i < 64; i++) fr[i] = 8'(i + 8'h40);
    for (int i = 0; i < 6; i++) fr[i] = da[47-8*i -: 8];
    fr[12] = ty[15:8]; fr[13] = ty[7:0];
    fr[14] = op[15:8]; fr[15] = op[7:0];
    fr[16] = q[15:8];  fr[17] = q[7:0];
  endtask

  task automatic send(int len, bit good, string req, bit exp_req, bit exp_bad, logic [15:0] exp_q);
    for (int i = 0; i < len; i++) begin
      @(negedge clk); rx_byte = fr[i]; rx_vld = 1;
    end
    @(negedge clk); rx_vld = 0; rx_good = good; rx_bad = !good;
    @(negedge clk); rx_good = 0; rx_bad = 0;
    chk({req, " req"}, 32'(pause_req), 32'(exp_req));
    chk({req, " badop"}, 32'(bad_opcode), 32'(exp_bad));
    chk({req, " quanta"}, 32'(pause_quanta), 32'(exp_q));
    @(negedge clk);
    chk({"R11 pulse after ", req}, 32'({pause_req, bad_opcode}), 32'(0));
    chk({"R11 hold after ", req}, 32'(pause_quanta), 32'(exp_q));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 req", 32'(pause_req), 0);
    chk("R1 badop", 32'(bad_opcode), 0);
    chk("R1 quanta", 32'(pause_quanta), 0);
    rst_n = 1;
    // R2 R4: station address AA-BB-CC-DD-EE-FF, minimum 18 bytes
    build(48'hAABBCCDDEEFF, 16'h8808, 16'h0001, 16'h1234);
    send(18, 1, "R2 R4 station", 1, 0, 16'h1234);
    // R3: reserved multicast
    build(48'h0180C2000001, 16'h8808, 16'h0001, 16'hABCD);
    send(20, 1, "R3 multicast", 1, 0, 16'hABCD);
    // R5: wrong destination (byte order reversed)
    build(48'hFFEEDDCCBBAA, 16'h8808, 16'h0001, 16'h1111);
    send(20, 1, "R5 wrong da", 0, 0, 16'hABCD);
    // R6: wrong type
    build(48'hAABBCCDDEEFF, 16'h0800, 16'h0002, 16'h2222);
    send(20, 1, "R6 wrong type", 0, 0, 16'hABCD);
    // R7: non-pause opcode, foreign address, enable low
    pause_en = 0;
    build(48'h123456789ABC, 16'h8808, 16'h0002, 16'h3333);
    send(20, 1, "R7 bad opcode", 0, 1, 16'hABCD);
    // R9: enable low
    build(48'hAABBCCDDEEFF, 16'h8808, 16'h0001, 16'h4444);
    send(20, 1, "R9 disabled", 0, 0, 16'hABCD);
    pause_en = 1;
    // R8: bad verdict
    build(48'hAABBCCDDEEFF, 16'h8808, 16'h0001, 16'h5555);
    send(20, 0, "R8 bad frame", 0, 0, 16'hABCD);
    // R10: 17 bytes only
    build(48'hAABBCCDDEEFF, 16'h8808, 16'h0001, 16'h6666);
    send(17, 1, "R10 short", 0, 0, 16'hABCD);
    // R12: long frame, tail ignored
    build(48'hAABBCCDDEEFF, 16'h8808, 16'h0001, 16'h00FF);
    send(64, 1, "R12 long", 1, 0, 16'h00FF);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule